// File: doc/BRIEF.md
# Byte ALU with Carry and Zero Flags

This block is the data path of a small soft microcontroller. It takes a source register value and a second operand, which is either another register or an immediate byte. It also takes a four-bit operation code. For add, subtract, bitwise logic, compare, test and the single-bit shift and rotate family, it produces the result, the next carry flag, the next zero flag, and a write strobe for the register file. The carry flag is held inside the block. It serves as the carry-in for chained additions and as the borrow for chained subtractions. It is also the bit source or bit sink when a shift runs across several bytes.

The datapath is combinational. The two flags are registered, and they load only on cycles where `op_valid` is high. The datapath width is the parameter `WIDTH`, which defaults to 8 bits. Compare and test change the flags and leave every register untouched. This lets a program branch on the flags without spending a register.

Top module: `alu8_core`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry): `result` is (a + b + cin) modulo 2^WIDTH. Here cin is the held carry for code 1 and 0 for code 0. `carry_nxt` is the carry out of the top bit.
- R2: Codes 2 (subtract) and 3 (subtract with borrow): `result` is (a - b - bin) modulo 2^WIDTH. Here bin is the held carry for code 3 and 0 for code 2. `carry_nxt` is 1 exactly when the true difference is negative.
- R3: Code 7 (compare): the flags are set as for code 2, so zero means a equals b and carry means a < b. `wr_en` is 0.
- R4: Codes 4, 5 and 6 give a AND b, a OR b and a XOR b bit by bit. `carry_nxt` is 0 for all three.
- R5: Code 8 (test): `zero_nxt` is 1 when (a AND b) is all zeros. `carry_nxt` is the XOR of all bits of (a AND b). `wr_en` is 0.
- R6: The right moves operate on a, and `carry_nxt` takes bit 0 of a. The top bit of the result is filled as follows: code 9 fills it with 0, code 10 fills it with the held carry, and code 13 fills it with bit 0 of a.
- R7: The left moves operate on a, and `carry_nxt` takes the top bit of a. Bit 0 of the result is filled as follows: code 11 fills it with 0, code 12 fills it with the held carry, and code 14 fills it with the top bit of a.
- R8: For codes 0 to 14, `zero_nxt` is 1 exactly when the computed value is all zeros.
- R9: `wr_en` is 1 for codes 0 to 6 and 9 to 14, and 0 for codes 7, 8 and 15.
- R10: On a clock edge with `op_valid` high, `carry_q` and `zero_q` take `carry_nxt` and `zero_nxt`. With `op_valid` low, they hold their values.
- R11: A clock edge with `rst_n` low clears `carry_q` and `zero_q`.
- R12: Code 15 is a no-operation. `result` is 0 and `wr_en` is 0. `carry_nxt` and `zero_nxt` equal the held flags, so a valid code 15 leaves the flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation executes this cycle; the flags load on the edge |
| op_code | input | 4 | Operation code, values as in the requirements |
| opnd_a | input | WIDTH | First operand (source register) |
| opnd_b | input | WIDTH | Second operand (register or immediate) |
| result | output | WIDTH | Computed value |
| wr_en | output | 1 | Register file should store `result` |
| carry_nxt | output | 1 | Carry flag the operation produces |
| zero_nxt | output | 1 | Zero flag the operation produces |
| carry_q | output | 1 | Held carry flag |
| zero_q | output | 1 | Held zero flag |

## Verification
The bench builds the block with `WIDTH` set to 4. This makes a full sweep practical: every operation code, every pair of operands, and both states of the held carry. That covers every wrap, underflow, equality and end-bit case of the full operand space, including the all-ones and all-zeros edges where carry and zero interact. The same width is used for directed sequences. These check that the flags hold while `op_valid` is low, that reset clears them, and that the no-operation code leaves them unchanged whether zero is set or clear.

// File: rtl/alu8_pkg.sv
// Package: operation codes shared by the ALU, its checker and its users.
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBC  = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_XOR   = 4'd6,
        OP_CMP   = 4'd7,
        OP_TEST  = 4'd8,
        OP_SHR_Z = 4'd9,
        OP_SHR_C = 4'd10,
        OP_SHL_Z = 4'd11,
        OP_SHL_C = 4'd12,
        OP_ROR   = 4'd13,
        OP_ROL   = 4'd14,
        OP_NONE  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef enum logic [1:0] {
        FILL_ZERO  = 2'd0,
        FILL_CARRY = 2'd1,
        FILL_WRAP  = 2'd2
    } fill_sel_e;
endpackage

// File: rtl/alu8_addsub.sv
// Module: adder/subtractor with carry or borrow in and out.
// Assumes: sub_mode selects a - b - cin; otherwise a + b + cin.
// The carry out is the extra top bit, which in subtract mode is the borrow.
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] ext_sum;

    // Widen by one bit so the carry or borrow falls out of the top bit.
    always_comb begin
        if (sub_mode)
            ext_sum = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, cin};
        else
            ext_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    end

    assign sum  = ext_sum[WIDTH-1:0];
    assign cout = ext_sum[WIDTH];
endmodule

// File: rtl/alu8_bitwise.sv
// Module: bitwise AND/OR/XOR, plus the parity of the AND value used by test.
// Assumes: sel takes only the three codes in logic_sel_e.
module alu8_bitwise #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]          a,
    input  logic [WIDTH-1:0]          b,
    input  alu8_pkg::logic_sel_e      sel,
    output logic [WIDTH-1:0]          res,
    output logic                      and_parity
);
    import alu8_pkg::*;

    logic [WIDTH-1:0] and_v;

    assign and_v      = a & b;
    assign and_parity = ^and_v;

    // Pick one bitwise function.
    always_comb begin
        case (sel)
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = and_v;
        endcase
    end
endmodule

// File: rtl/alu8_shifter.sv
// Module: one-bit shift or rotate, left or right.
// Assumes: the fill mode picks the bit entering the vacated end
// (zero, held carry, or the bit leaving the other end).
// The bit that leaves always becomes the carry out.
module alu8_shifter #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]      a,
    input  logic                  cin,
    input  logic                  go_left,
    input  alu8_pkg::fill_sel_e   fill,
    output logic [WIDTH-1:0]      res,
    output logic                  cout
);
    import alu8_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic out_bit;
    logic in_bit;

    assign out_bit = go_left ? a[MSB] : a[0];

    // Choose the bit that enters the vacated position.
    always_comb begin
        case (fill)
            FILL_CARRY: in_bit = cin;
            FILL_WRAP:  in_bit = out_bit;
            default:    in_bit = 1'b0;
        endcase
    end

    // Move every bit one place and insert the fill bit.
    always_comb begin
        if (go_left)
            res = {a[MSB-1:0], in_bit};
        else
            res = {in_bit, a[MSB:1]};
    end

    assign cout = out_bit;
endmodule

// File: rtl/alu8_core.sv
// Module: ALU top. It decodes the operation, steers the operands into the
// add/sub, bitwise and shift units, forms the next flags and the write
// strobe, and holds carry and zero in registers.
// Assumes: synchronous active-low reset; the flags load only while
// op_valid is high.
module alu8_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic             carry_nxt,
    output logic             zero_nxt,
    output logic             carry_q,
    output logic             zero_q
);
    import alu8_pkg::*;

    alu_op_e          op;
    logic             as_sub;
    logic             as_cin;
    logic [WIDTH-1:0] as_sum;
    logic             as_cout;
    logic_sel_e       lg_sel;
    logic [WIDTH-1:0] lg_res;
    logic             lg_par;
    logic             sh_left;
    fill_sel_e        sh_fill;
    logic [WIDTH-1:0] sh_res;
    logic             sh_cout;
    logic [WIDTH-1:0] value;
    logic             carry_calc;

    assign op = alu_op_e'(op_code);

    // Adder controls: subtract family and carry-chained variants.
    always_comb begin
        as_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
        as_cin = ((op == OP_ADDC) || (op == OP_SUBC)) ? carry_q : 1'b0;
    end

    // Bitwise function select.
    always_comb begin
        case (op)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    // Shift direction and fill mode.
    always_comb begin
        sh_left = (op == OP_SHL_Z) || (op == OP_SHL_C) || (op == OP_ROL);
        case (op)
            OP_SHR_C, OP_SHL_C: sh_fill = FILL_CARRY;
            OP_ROR, OP_ROL:     sh_fill = FILL_WRAP;
            default:            sh_fill = FILL_ZERO;
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a        (opnd_a),
        .b        (opnd_b),
        .cin      (as_cin),
        .sub_mode (as_sub),
        .sum      (as_sum),
        .cout     (as_cout)
    );

    alu8_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a          (opnd_a),
        .b          (opnd_b),
        .sel        (lg_sel),
        .res        (lg_res),
        .and_parity (lg_par)
    );

    alu8_shifter #(.WIDTH(WIDTH)) u_shifter (
        .a       (opnd_a),
        .cin     (carry_q),
        .go_left (sh_left),
        .fill    (sh_fill),
        .res     (sh_res),
        .cout    (sh_cout)
    );

    // Select the computed value and its carry by operation class.
    always_comb begin
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                value      = as_sum;
                carry_calc = as_cout;
            end
            OP_AND, OP_OR, OP_XOR: begin
                value      = lg_res;
                carry_calc = 1'b0;
            end
            OP_TEST: begin
                value      = lg_res;
                carry_calc = lg_par;
            end
            OP_NONE: begin
                value      = '0;
                carry_calc = carry_q;
            end
            default: begin
                value      = sh_res;
                carry_calc = sh_cout;
            end
        endcase
    end

    // Form the outputs; a no-operation passes the held flags through.
    always_comb begin
        result    = value;
        carry_nxt = carry_calc;
        zero_nxt  = (op == OP_NONE) ? zero_q : (value == '0);
        wr_en     = !((op == OP_CMP) || (op == OP_TEST) || (op == OP_NONE));
    end

    // Flag registers: clear on reset, load on a valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else if (op_valid) begin
            carry_q <= carry_nxt;
            zero_q  <= zero_nxt;
        end
    end
endmodule

// File: rtl/alu8_core_chk.sv
// Module: property checker for alu8_core, attached by bind below.
// Assumes: it sees the top-level ports only.
module alu8_core_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [3:0]       op_code,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] result,
    input logic             wr_en,
    input logic             carry_nxt,
    input logic             zero_nxt,
    input logic             carry_q,
    input logic             zero_q
);
    import alu8_pkg::*;

    p_flag_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (carry_q == $past(carry_nxt)) && (zero_q == $past(zero_nxt)));

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(carry_q) && $stable(zero_q));

    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> !carry_q && !zero_q);

    p_cmp_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_CMP) |-> !wr_en && (zero_nxt == (opnd_a == opnd_b))
                                && (carry_nxt == (opnd_a < opnd_b)));

    p_logic_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR))
        |-> !carry_nxt);

    p_shr_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_SHR_Z) |-> !result[WIDTH-1] && (carry_nxt == opnd_a[0]));

    p_zero_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (zero_nxt == (result == '0)));

    p_noop_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_NONE) |-> !wr_en && (carry_nxt == carry_q)
                                 && (zero_nxt == zero_q));
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .wr_en     (wr_en),
    .carry_nxt (carry_nxt),
    .zero_nxt  (zero_nxt),
    .carry_q   (carry_q),
    .zero_q    (zero_q)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep at WIDTH=4 plus directed flag sequences.
module alu8_core_tb;
    localparam int W = 4;
    localparam int M = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = 4'd15;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         wr_en, carry_nxt, zero_nxt, carry_q, zero_q;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    alu8_core #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .wr_en(wr_en),
        .carry_nxt(carry_nxt), .zero_nxt(zero_nxt),
        .carry_q(carry_q), .zero_q(zero_q)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 1:         return "R1";
            2, 3:         return "R2";
            7:            return "R3";
            4, 5, 6:      return "R4";
            8:            return "R5";
            9, 10, 13:    return "R6";
            11, 12, 14:   return "R7";
            default:      return "R12";
        endcase
    endfunction

    // Reference model computed from the requirements.
    task automatic model(input int op, input int a, input int b, input int c,
                         input int z, output int res, output int co,
                         output int zo, output int we);
        int t;
        co = 0;
        case (op)
            0: begin t = a + b;     res = t & M; co = (t >> W) & 1; end
            1: begin t = a + b + c; res = t & M; co = (t >> W) & 1; end
            2, 7: begin t = a - b;  res = t & M; co = (t < 0) ? 1 : 0; end
            3: begin t = a - b - c; res = t & M; co = (t < 0) ? 1 : 0; end
            4: res = a & b;
            5: res = a | b;
            6: res = a ^ b;
            8: begin res = a & b; co = $countones(res[W-1:0]) & 1; end
            9:  begin res = a >> 1; co = a & 1; end
            10: begin res = (a >> 1) | (c << (W-1)); co = a & 1; end
            13: begin res = (a >> 1) | ((a & 1) << (W-1)); co = a & 1; end
            11: begin res = (a << 1) & M; co = (a >> (W-1)) & 1; end
            12: begin res = ((a << 1) & M) | c; co = (a >> (W-1)) & 1; end
            14: begin res = ((a << 1) & M) | ((a >> (W-1)) & 1); co = (a >> (W-1)) & 1; end
            default: begin res = 0; co = c; end
        endcase
        zo = (op == 15) ? z : ((res == 0) ? 1 : 0);
        we = (op == 7 || op == 8 || op == 15) ? 0 : 1;
    endtask

    // Drive one valid operation at the falling edge.
    task automatic drive(input int op, input int a, input int b, input logic v);
        @(negedge clk);
        op_code  = op[3:0];
        opnd_a   = a[W-1:0];
        opnd_b   = b[W-1:0];
        op_valid = v;
    endtask

    // Put the held flags into a known state: carry = c, zero = z.
    task automatic set_flags(input int c, input int z);
        if (c == 1 && z == 0) drive(2, 0, 1, 1'b1);
        else if (c == 1)      drive(0, M, 1, 1'b1);
        else if (z == 1)      drive(4, 0, 0, 1'b1);
        else                  drive(5, 1, 0, 1'b1);
    endtask

    task automatic check_flags(input string rq, input int ec, input int ez);
        @(posedge clk); #1;
        n_vec++;
        if (carry_q !== ec[0] || zero_q !== ez[0]) begin
            n_bad++;
            $display("FAIL %s flags actual c=%0b z=%0b expected c=%0d z=%0d",
                     rq, carry_q, zero_q, ec, ez);
        end
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        int res, co, zo, we;
        // R11: flags are clear after reset.
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (carry_q !== 1'b0 || zero_q !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 reset actual c=%0b z=%0b expected 0 0", carry_q, zero_q);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweep: every op, operand pair and held carry (R1-style
        // per-op tags come from req_of; R8 and R9 are checked on every vector).
        for (int op = 0; op < 16; op++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a <= M; a++) begin
                    for (int b = 0; b <= M; b++) begin
                        set_flags(c, 0);
                        drive(op, a, b, 1'b1);
                        #1;
                        model(op, a, b, c, 0, res, co, zo, we);
                        n_vec++;
                        if ((op != 7 && op != 8 && result !== res[W-1:0]) ||
                            carry_nxt !== co[0] || zero_nxt !== zo[0] ||
                            wr_en !== we[0]) begin
                            n_bad++;
                            $display("FAIL %s/R8/R9 op=%0d a=%0d b=%0d c=%0d actual r=%0d c=%0b z=%0b we=%0b expected r=%0d c=%0d z=%0d we=%0d",
                                     req_of(op), op, a, b, c, result, carry_nxt,
                                     zero_nxt, wr_en, res, co, zo, we);
                        end
                        check_flags("R10", co, zo);
                    end
                end
            end
        end

        // R12: no-operation with zero set keeps both flags.
        set_flags(1, 1);
        drive(15, 3, 5, 1'b1);
        check_flags("R12", 1, 1);
        set_flags(0, 1);
        drive(15, 7, 7, 1'b1);
        check_flags("R12", 0, 1);

        // R10: flags hold while op_valid is low.
        set_flags(1, 0);
        drive(0, 0, 0, 1'b0);
        check_flags("R10", 1, 0);
        drive(2, 0, 1, 1'b0);
        set_flags(0, 1);
        drive(2, 0, 1, 1'b0);
        check_flags("R10", 0, 1);

        // R11: reset mid-run clears set flags.
        set_flags(1, 1);
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b0;
        check_flags("R11", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule